// File: doc/BRIEF.md
# Quadrature encoder event counter

This block counts transitions on two external pins, `in1` and `in2`. In the simple counting mode only `in1` is used, and each of its active transitions adds one to the count. In the encoder mode the two pins are treated as a quadrature pair. Each active transition on one pin moves the count up or down, and the direction comes from the edge polarity together with the level of the other pin. The active edge can be rising only, falling only, or both. This gives two or four counts per encoder cycle. The count runs between zero and a programmable wrap limit and wraps in either direction.

Software reaches the block through a small word-wide register port. It sets the mode and the active edge while the block is disabled. It then sets the enable bit and loads the wrap limit and a compare value. Each of these two loads raises its own completion flag, and software clears the flags through a separate write-only register. Counting begins when a start command is written. Clearing the enable bit stops the counter and zeroes the count.

Top module: `qenc_counter`

## Requirements
- R1: After reset, every register reads back as follows: count 0, wrap limit all ones (0xFFFF), compare 0, control 0, configuration 0 (simple mode, rising edge), and status 0.
- R2: The register map is: 0 control (bit0 enable, bit1 start); 1 configuration (bit0 encoder mode, bits 2:1 edge select: 0 rising, 1 falling, 2 or 3 both); 2 wrap limit; 3 compare; 4 status, read only (bit0 limit loaded, bit1 compare loaded); 5 flag clear, write only (a 1 clears the matching status bit); 6 count, read only. In simple mode the count goes up by one on each active edge of `in1`, and `in2` has no effect.
- R3: In encoder mode with rising edges selected, the direction depends on which pin rises and on the level of the other pin. `in1` rising counts up when `in2` is low and down when `in2` is high. `in2` rising counts up when `in1` is high and down when `in1` is low. Falling transitions are ignored.
- R4: In encoder mode with falling edges selected, `in1` falling counts up when `in2` is high and down when `in2` is low. `in2` falling counts up when `in1` is low and down when `in1` is high. Rising transitions are ignored.
- R5: In encoder mode with both edges selected, the rules of R3 and R4 apply together, giving four counts per full encoder cycle.
- R6: In encoder mode, a clock cycle in which both synchronized pins show a transition leaves the count unchanged.
- R7: The count never exceeds the wrap limit. Counting up from the limit gives 0, and counting down from 0 gives the limit.
- R8: Writes to the configuration register while enable is set are ignored.
- R9: Writes to the wrap limit and compare registers take effect only while enable is set and counting has not started, and each accepted write sets its status flag. Writes made while disabled or while counting leave the register and its flag unchanged.
- R10: A write to the flag clear register clears exactly the status bits written as 1.
- R11: The count moves only after the start bit is written while enable is already set. Writing enable as 0 stops counting and sets the count to 0.
- R12: With the default two synchronizer stages, a pin change applied before a clock edge shows in the count after the third rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in1 | input | 1 | Count pin, or first encoder phase |
| in2 | input | 1 | Second encoder phase |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |

## Verification
The bench builds the block with its defaults: a 16-bit count and two synchronizer stages. With these, the three-edge pin-to-count latency is fixed and can be checked cycle by cycle. The bench loads small wrap limits such as 2 and 100. These bring the wrap in both directions within a few pin transitions. The reset value of 0xFFFF is checked only by readback.

// File: rtl/qenc_counter.sv
module qenc_counter #(
  parameter int CW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in1,
  input  logic          in2,
  input  logic          bus_we,
  input  logic [2:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata
);
  localparam logic [2:0] A_CTRL = 3'd0, A_CFG = 3'd1, A_LIM = 3'd2, A_CMP = 3'd3,
                         A_STAT = 3'd4, A_CLR = 3'd5, A_CNT = 3'd6;
  localparam logic [CW-1:0] LIM_MAX = {CW{1'b1}};

  logic [SYNC-1:0] sy1, sy2;
  logic            p1, p2;
  logic            en_q, run_q, quad_q;
  logic [1:0]      edge_q;
  logic [CW-1:0]   lim_q, cmp_q, cnt_q;
  logic            lim_ok, cmp_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
      p1  <= 1'b0;
      p2  <= 1'b0;
    end else begin
      sy1 <= {sy1[SYNC-2:0], in1};
      sy2 <= {sy2[SYNC-2:0], in2};
      p1  <= sy1[SYNC-1];
      p2  <= sy2[SYNC-1];
    end
  end

  wire s1 = sy1[SYNC-1];
  wire s2 = sy2[SYNC-1];
  wire r1 = s1 & ~p1;
  wire f1 = ~s1 & p1;
  wire r2 = s2 & ~p2;
  wire f2 = ~s2 & p2;

  wire use_r = (edge_q != 2'd1);
  wire use_f = (edge_q != 2'd0);
  wire e1 = (use_r & r1) | (use_f & f1);
  wire e2 = (use_r & r2) | (use_f & f2);
  wire both_tr = (r1 | f1) & (r2 | f2);

  logic step, up;
  always_comb begin
    step = 1'b0;
    up   = 1'b1;
    if (!quad_q) begin
      step = e1;
    end else if (!both_tr) begin
      if (e1) begin
        step = 1'b1;
        up   = r1 ^ s2;
      end else if (e2) begin
        step = 1'b1;
        up   = ~(r2 ^ s1);
      end
    end
  end

  wire [CW-1:0] cnt_nx = up ? ((cnt_q == lim_q) ? '0 : cnt_q + 1'b1)
                            : ((cnt_q == '0) ? lim_q : cnt_q - 1'b1);

  wire wr_ctrl = bus_we && bus_addr == A_CTRL;
  wire wr_cfg  = bus_we && bus_addr == A_CFG && !en_q;
  wire wr_lim  = bus_we && bus_addr == A_LIM && en_q && !run_q;
  wire wr_cmp  = bus_we && bus_addr == A_CMP && en_q && !run_q;
  wire wr_clr  = bus_we && bus_addr == A_CLR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (wr_ctrl && !bus_wdata[0]) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q <= 1'b1;
        if (en_q && bus_wdata[1]) run_q <= 1'b1;
      end
      if (run_q && step) cnt_q <= cnt_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_q <= 1'b0;
      edge_q <= 2'd0;
      lim_q  <= LIM_MAX;
      cmp_q  <= '0;
      lim_ok <= 1'b0;
      cmp_ok <= 1'b0;
    end else begin
      if (wr_cfg) begin
        quad_q <= bus_wdata[0];
        edge_q <= bus_wdata[2:1];
      end
      if (wr_lim) begin
        lim_q  <= bus_wdata;
        lim_ok <= 1'b1;
      end
      if (wr_cmp) begin
        cmp_q  <= bus_wdata;
        cmp_ok <= 1'b1;
      end
      if (wr_clr) begin
        if (bus_wdata[0]) lim_ok <= 1'b0;
        if (bus_wdata[1]) cmp_ok <= 1'b0;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[1:0] = {run_q, en_q};
      A_CFG:  bus_rdata[2:0] = {edge_q, quad_q};
      A_LIM:  bus_rdata = lim_q;
      A_CMP:  bus_rdata = cmp_q;
      A_STAT: bus_rdata[1:0] = {cmp_ok, lim_ok};
      A_CNT:  bus_rdata = cnt_q;
      default: bus_rdata = '0;
    endcase
  end

  p_cnt_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q <= lim_q);
  p_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && step && up && cnt_q == lim_q && !wr_ctrl) |=> cnt_q == '0);
  p_wrap_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && step && !up && cnt_q == '0 && !wr_ctrl) |=> cnt_q == $past(lim_q));
  p_dual_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && quad_q && both_tr && !wr_ctrl) |=> $stable(cnt_q));
  p_cfg_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> ($stable(quad_q) && $stable(edge_q)));
  p_lim_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_LIM && en_q && !run_q) |=> lim_ok);
  p_lim_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(lim_q));
  p_run_needs_en_r11: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> en_q);
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> ($stable(cnt_q) || cnt_q == '0));
endmodule

// File: tb/sim_qenc_counter.sv
module sim_qenc_counter;
  logic clk = 1'b0, rst_n = 1'b0, in1 = 1'b0, in2 = 1'b0;
  logic bus_we = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  qenc_counter u0 (.clk(clk), .rst_n(rst_n), .in1(in1), .in2(in2), .bus_we(bus_we),
                   .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pins(input logic a, input logic b);
    @(negedge clk);
    in1 = a; in2 = b;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pins(1'b1, in2);
      pins(1'b0, in2);
    end
  endtask

  task automatic cnt_is(input string req, input logic [15:0] exp);
    logic [15:0] v;
    rd(3'd6, v);
    chk(req, v, exp);
  endtask

  task automatic setup(input logic quad, input logic [1:0] edge_sel, input logic [15:0] lim);
    wr(3'd0, 16'd0);
    pins(1'b0, 1'b0);
    wr(3'd1, {13'd0, edge_sel, quad});
    wr(3'd0, 16'd1);
    wr(3'd2, lim);
    wr(3'd5, 16'd3);
    wr(3'd0, 16'd3);
  endtask

  task automatic t_reset;
    logic [15:0] v;
    rd(3'd6, v); chk("R1 count", v, 16'd0);
    rd(3'd2, v); chk("R1 limit", v, 16'hFFFF);
    rd(3'd3, v); chk("R1 compare", v, 16'd0);
    rd(3'd0, v); chk("R1 control", v, 16'd0);
    rd(3'd1, v); chk("R1 config", v, 16'd0);
    rd(3'd4, v); chk("R1 status", v, 16'd0);
  endtask

  task automatic t_simple;
    setup(1'b0, 2'd0, 16'd100);
    pulses(3); cnt_is("R2 rising", 16'd3);
    pins(1'b0, 1'b1); pins(1'b0, 1'b0); cnt_is("R2 in2 ignored", 16'd3);
    setup(1'b0, 2'd1, 16'd100);
    pulses(3); cnt_is("R2 falling", 16'd3);
    setup(1'b0, 2'd2, 16'd100);
    pulses(3); cnt_is("R2 both", 16'd6);
  endtask

  task automatic t_quad_rise;
    setup(1'b1, 2'd0, 16'd100);
    pins(1'b1, 1'b0); cnt_is("R3 in1 up in2 low", 16'd1);
    pins(1'b1, 1'b1); cnt_is("R3 in2 up in1 high", 16'd2);
    pins(1'b0, 1'b1); pins(1'b0, 1'b0); cnt_is("R3 falls ignored", 16'd2);
    pins(1'b0, 1'b1); cnt_is("R3 in2 up in1 low", 16'd1);
    pins(1'b1, 1'b1); cnt_is("R3 in1 up in2 high", 16'd0);
  endtask

  task automatic t_quad_fall;
    setup(1'b1, 2'd1, 16'd100);
    pins(1'b1, 1'b0); pins(1'b1, 1'b1); cnt_is("R4 rises ignored", 16'd0);
    pins(1'b0, 1'b1); cnt_is("R4 in1 fall in2 high", 16'd1);
    pins(1'b0, 1'b0); cnt_is("R4 in2 fall in1 low", 16'd2);
    pins(1'b0, 1'b1); pins(1'b1, 1'b1);
    pins(1'b1, 1'b0); cnt_is("R4 in2 fall in1 high", 16'd1);
    pins(1'b0, 1'b0); cnt_is("R4 in1 fall in2 low", 16'd0);
  endtask

  task automatic t_quad_both;
    setup(1'b1, 2'd2, 16'd100);
    pins(1'b1, 1'b0); pins(1'b1, 1'b1); pins(1'b0, 1'b1); pins(1'b0, 1'b0);
    cnt_is("R5 four per cycle", 16'd4);
    pins(1'b0, 1'b1); pins(1'b1, 1'b1); pins(1'b1, 1'b0); pins(1'b0, 1'b0);
    cnt_is("R5 reverse cycle", 16'd0);
    pins(1'b0, 1'b1); cnt_is("R7 wrap down", 16'd100);
  endtask

  task automatic t_dual;
    setup(1'b1, 2'd2, 16'd100);
    pins(1'b1, 1'b1); cnt_is("R6 dual edge", 16'd0);
    pins(1'b0, 1'b0); cnt_is("R6 dual fall", 16'd0);
  endtask

  task automatic t_wrap_up;
    setup(1'b0, 2'd0, 16'd2);
    pulses(2); cnt_is("R7 at limit", 16'd2);
    pulses(1); cnt_is("R7 wrap up", 16'd0);
  endtask

  task automatic t_locks;
    logic [15:0] v;
    setup(1'b0, 2'd0, 16'd50);
    wr(3'd1, 16'd5);
    rd(3'd1, v); chk("R8 config locked", v, 16'd0);
    wr(3'd2, 16'd7);
    rd(3'd2, v); chk("R9 limit locked running", v, 16'd50);
    rd(3'd4, v); chk("R9 no flag running", v, 16'd0);
    wr(3'd0, 16'd0);
    wr(3'd3, 16'd9);
    rd(3'd3, v); chk("R9 compare ignored disabled", v, 16'd0);
    rd(3'd4, v); chk("R9 no flag disabled", v, 16'd0);
  endtask

  task automatic t_flags;
    logic [15:0] v;
    wr(3'd0, 16'd0);
    wr(3'd0, 16'd1);
    wr(3'd2, 16'd20);
    rd(3'd4, v); chk("R9 limit flag", v, 16'd1);
    rd(3'd2, v); chk("R9 limit value", v, 16'd20);
    wr(3'd3, 16'd11);
    rd(3'd4, v); chk("R9 both flags", v, 16'd3);
    rd(3'd3, v); chk("R9 compare value", v, 16'd11);
    wr(3'd5, 16'd1);
    rd(3'd4, v); chk("R10 clear bit0", v, 16'd2);
    wr(3'd5, 16'd2);
    rd(3'd4, v); chk("R10 clear bit1", v, 16'd0);
  endtask

  task automatic t_start;
    wr(3'd0, 16'd0);
    pins(1'b0, 1'b0);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd3);
    pulses(1); cnt_is("R11 start with enable ignored", 16'd0);
    wr(3'd0, 16'd1);
    pulses(1); cnt_is("R11 enabled not started", 16'd0);
    wr(3'd0, 16'd3);
    pulses(2); cnt_is("R11 started", 16'd2);
    wr(3'd0, 16'd0);
    cnt_is("R11 disable zeroes", 16'd0);
    pulses(1); cnt_is("R11 stopped", 16'd0);
  endtask

  task automatic t_latency;
    logic [15:0] v;
    setup(1'b0, 2'd0, 16'd100);
    bus_addr = 3'd6;
    @(negedge clk); in1 = 1'b1;
    @(negedge clk); chk("R12 after edge 1", bus_rdata, 16'd0);
    @(negedge clk); chk("R12 after edge 2", bus_rdata, 16'd0);
    @(negedge clk); chk("R12 after edge 3", bus_rdata, 16'd1);
    pins(1'b0, 1'b0);
    rd(3'd6, v); chk("R12 settled", v, 16'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_simple;
    t_quad_rise;
    t_quad_fall;
    t_quad_both;
    t_dual;
    t_wrap_up;
    t_locks;
    t_flags;
    t_start;
    t_latency;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule